// File: doc/BRIEF.md
# Level-1 Data Cache Snoop Response Handler

This block is the coherence-facing half of a small two-way set-associative level-1 data cache. Level 2 sends it snoop commands while its own DMA traffic touches memory that level 1 may be holding. A snoop-read returns one chunk of a present line. A snoop-write merges one chunk of new data into a present line. Neither command alters the line's valid, dirty or replacement state. A line that the CPU dirtied is therefore still written back when it is later evicted, and that write-back carries any snooped data.

On the CPU side, the block serves loads and stores through a request/acknowledge port. On a miss it talks to level 2 over a single request port. It first writes back a dirty victim line if there is one. It then issues a line read that states whether the line will be allocated and into which way. A load marked non-cacheable that misses is fetched without allocation, and its word is returned directly. Stores always allocate.

Top module: `l1_snoop_cache`

## Requirements
- R1: After reset every line is invalid: a snoop to any line is answered as a miss, and no level-2 request is pending.
- R2: A snoop-read of a present line is acknowledged in the cycle after the command with `snp_hit`=1. `snp_rdata` holds the addressed chunk, with the lowest-offset word in the least significant bits. The chunk is selected by the low bits of `snp_caddr`, and the line by the remaining bits {tag, set}.
- R3: Snoop-reads and snoop-writes leave the valid, dirty and LRU state of every line unchanged. In particular, a dirty line stays dirty across snoops.
- R4: A snoop-write that hits replaces exactly the CHUNK_WORDS words of the addressed chunk, whether the line is clean or dirty, and leaves the line's other words untouched.
- R5: A snoop-write does not set the dirty bit: a clean line that received snooped data is evicted without a write-back.
- R6: When a dirty line is chosen as victim, a write-back (`l2_we`=1) of its current contents to its own line address precedes the read of the new line, and it carries any snooped data.
- R7: Every line read sent to level 2 carries `l2_alloc`. It is 0 for a non-cacheable load miss and 1 for any other miss. `l2_way` is the way that will be filled. A non-allocating load returns the addressed word of `l2_rdata` and leaves the cache unchanged. A non-cacheable load that hits is served from the cache. A level-2 request holds its address and direction until `l2_ack`.
- R8: A snoop takes priority over a CPU access in the same cycle: `cpu_ack` stays 0 while `snp_valid` is 1, and the CPU access completes in a later cycle.
- R9: The victim is an invalid way if one exists (way 0 before way 1). Otherwise it is the way that was not the most recently touched by a CPU hit or a fill.
- R10: A snoop that misses is acknowledged with `snp_hit`=0 and `snp_rdata`=0, and changes no data or state.
- R11: A CPU load that hits returns the addressed word with `cpu_ack` in the same cycle and makes no level-2 request. A store hit writes the word and marks the line dirty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_req | input | 1 | CPU access request, held until `cpu_ack` |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_nocache | input | 1 | Load must not allocate on a miss |
| cpu_addr | input | ADDR_W | Word address {tag, set, offset} |
| cpu_wdata | input | DATA_W | Store data |
| cpu_ack | output | 1 | Access completes this cycle |
| cpu_rdata | output | DATA_W | Load data, valid with `cpu_ack` |
| snp_valid | input | 1 | Snoop command strobe, one cycle per command |
| snp_write | input | 1 | 1 = snoop-write, 0 = snoop-read |
| snp_caddr | input | ADDR_W-OFF_W+CK_W | Chunk address {tag, set, chunk} |
| snp_wdata | input | CHUNK_W | Snoop-write data |
| snp_ack | output | 1 | Snoop response, one cycle after the command |
| snp_hit | output | 1 | Snooped line was present |
| snp_rdata | output | CHUNK_W | Snoop-read data, zero otherwise |
| l2_req | output | 1 | Level-2 request, held until `l2_ack` |
| l2_we | output | 1 | 1 = victim write-back, 0 = line read |
| l2_addr | output | ADDR_W-OFF_W | Line address {tag, set} |
| l2_alloc | output | 1 | Line read will be allocated |
| l2_way | output | 1 | Way that the fill will use |
| l2_wdata | output | WORDS*DATA_W | Write-back line |
| l2_ack | input | 1 | Level 2 accepts the request (read data valid) |
| l2_rdata | input | WORDS*DATA_W | Line read data |

## Verification
The bench builds the block with 16-bit words, 8-bit word addresses, two sets, four-word lines and two-word chunks. With only two sets of two ways, a third tag in a set forces an eviction after a handful of accesses. This makes it practical to steer the LRU bit deliberately and to watch whether the snooped lines are written back. Two chunks per line place a snoop-write in either half, so a merge into the wrong chunk shows up at once. The load sweep covers every word of every set and way against data computed from the address.

// File: rtl/l1s_pkg.sv
// Shared types for the level-1 snoop-aware data cache.
package l1s_pkg;
    // Miss-handling controller states.
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,   // serving CPU hits and snoops
        ST_WBACK = 2'd1,   // dirty victim being written to level 2
        ST_FILL  = 2'd2,   // line read outstanding at level 2
        ST_NCRET = 2'd3    // non-allocated load word waiting to be returned
    } ctl_state_t;
endpackage

// File: rtl/l1s_tag_store.sv
// Tag, valid, dirty and LRU state of a 2-way set-associative cache.
// Port A looks up a CPU address and reports the victim of its set; port B
// looks up a snoop address only. Snoops therefore have no path to any state.
// Assumes SETS is a power of two, at least 2.
module l1s_tag_store #(
    parameter int SETS  = 16,
    parameter int TAG_W = 8,
    localparam int IDX_W = $clog2(SETS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] a_idx,
    input  logic [TAG_W-1:0] a_tag,
    output logic             a_hit,
    output logic             a_way,
    input  logic [IDX_W-1:0] b_idx,
    input  logic [TAG_W-1:0] b_tag,
    output logic             b_hit,
    output logic             b_way,
    output logic             vic_way,
    output logic             vic_valid,
    output logic             vic_dirty,
    output logic [TAG_W-1:0] vic_tag,
    input  logic             touch_en,
    input  logic             touch_way,
    input  logic             touch_dirty,
    input  logic             inval_en,
    input  logic             inval_way,
    input  logic             fill_en,
    input  logic [IDX_W-1:0] fill_idx,
    input  logic             fill_way,
    input  logic [TAG_W-1:0] fill_tag
);
    logic [1:0]       valid_q [SETS];
    logic [1:0]       dirty_q [SETS];
    logic             lru_q   [SETS];
    logic [TAG_W-1:0] tag_q   [SETS][2];

    // CPU-side lookup.
    always_comb begin
        a_hit = 1'b0;
        a_way = 1'b0;
        for (int w = 0; w < 2; w++) begin
            if (valid_q[a_idx][w] && tag_q[a_idx][w] == a_tag) begin
                a_hit = 1'b1;
                a_way = 1'(w);
            end
        end
    end

    // Snoop-side lookup.
    always_comb begin
        b_hit = 1'b0;
        b_way = 1'b0;
        for (int w = 0; w < 2; w++) begin
            if (valid_q[b_idx][w] && tag_q[b_idx][w] == b_tag) begin
                b_hit = 1'b1;
                b_way = 1'(w);
            end
        end
    end

    // Victim choice: an empty way first, else the LRU way.
    always_comb begin
        if (!valid_q[a_idx][0])      vic_way = 1'b0;
        else if (!valid_q[a_idx][1]) vic_way = 1'b1;
        else                         vic_way = lru_q[a_idx];
        vic_valid = valid_q[a_idx][vic_way];
        vic_dirty = dirty_q[a_idx][vic_way];
        vic_tag   = tag_q[a_idx][vic_way];
    end

    // Valid, dirty and LRU updates from CPU hits, miss start and fills.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) begin
                valid_q[s] <= '0;
                dirty_q[s] <= '0;
                lru_q[s]   <= 1'b0;
            end
        end else begin
            if (touch_en) begin
                lru_q[a_idx] <= ~touch_way;
                if (touch_dirty) dirty_q[a_idx][touch_way] <= 1'b1;
            end
            if (inval_en) begin
                valid_q[a_idx][inval_way] <= 1'b0;
                dirty_q[a_idx][inval_way] <= 1'b0;
            end
            if (fill_en) begin
                valid_q[fill_idx][fill_way] <= 1'b1;
                dirty_q[fill_idx][fill_way] <= 1'b0;
                lru_q[fill_idx]             <= ~fill_way;
            end
        end
    end

    // Tag written on a fill.
    always_ff @(posedge clk) begin
        if (fill_en) tag_q[fill_idx][fill_way] <= fill_tag;
    end
endmodule

// File: rtl/l1s_data_store.sv
// Line data array of a 2-way cache, one packed line per {set, way} entry.
// Offers a full-line read for the CPU side, a chunk read for snoops, and
// three writes: CPU word, snoop chunk, and level-2 fill line. The controller
// guarantees that writes in one cycle target different entries.
module l1s_data_store #(
    parameter int SETS        = 16,
    parameter int WORDS       = 16,
    parameter int CHUNK_WORDS = 8,
    parameter int DATA_W      = 32,
    localparam int IDX_W   = $clog2(SETS),
    localparam int OFF_W   = $clog2(WORDS),
    localparam int CK_W    = $clog2(WORDS / CHUNK_WORDS),
    localparam int LINE_W  = WORDS * DATA_W,
    localparam int CHUNK_W = CHUNK_WORDS * DATA_W
) (
    input  logic               clk,
    input  logic [IDX_W-1:0]   rd_idx,
    input  logic               rd_way,
    output logic [LINE_W-1:0]  rd_line,
    input  logic               wr_word_en,
    input  logic [OFF_W-1:0]   wr_off,
    input  logic [DATA_W-1:0]  wr_word,
    input  logic [IDX_W-1:0]   sn_idx,
    input  logic               sn_way,
    input  logic [CK_W-1:0]    sn_chunk,
    output logic [CHUNK_W-1:0] sn_rdata,
    input  logic               sn_wr_en,
    input  logic [CHUNK_W-1:0] sn_wdata,
    input  logic               fill_en,
    input  logic [IDX_W-1:0]   fill_idx,
    input  logic               fill_way,
    input  logic [LINE_W-1:0]  fill_line
);
    localparam int ENTRIES = SETS * 2;

    logic [LINE_W-1:0] line_q [ENTRIES];

    // Combinational reads for the CPU side and the snoop side.
    assign rd_line  = line_q[{rd_idx, rd_way}];
    assign sn_rdata = line_q[{sn_idx, sn_way}][sn_chunk*CHUNK_W +: CHUNK_W];

    // Fill, CPU store and snoop merge writes.
    always_ff @(posedge clk) begin
        if (fill_en)    line_q[{fill_idx, fill_way}] <= fill_line;
        if (wr_word_en) line_q[{rd_idx, rd_way}][wr_off*DATA_W +: DATA_W] <= wr_word;
        if (sn_wr_en)   line_q[{sn_idx, sn_way}][sn_chunk*CHUNK_W +: CHUNK_W] <= sn_wdata;
    end
endmodule

// File: rtl/l1_snoop_cache.sv
// Level-1 data cache core with level-2 snoop handling.
// Snoops are served in the cycle they arrive, answered one cycle later, and
// change only line data. CPU accesses are served only in ST_IDLE cycles
// without a snoop. A miss writes back a dirty victim, then reads the line.
// The victim is invalidated when the miss starts, so a snoop cannot hit it.
// Assumes WORDS/CHUNK_WORDS >= 2 and all counts are powers of two.
module l1_snoop_cache #(
    parameter int ADDR_W      = 16,
    parameter int DATA_W      = 32,
    parameter int SETS        = 16,
    parameter int WORDS       = 16,
    parameter int CHUNK_WORDS = 8,
    localparam int OFF_W   = $clog2(WORDS),
    localparam int IDX_W   = $clog2(SETS),
    localparam int TAG_W   = ADDR_W - OFF_W - IDX_W,
    localparam int LA_W    = ADDR_W - OFF_W,
    localparam int CK_W    = $clog2(WORDS / CHUNK_WORDS),
    localparam int SA_W    = LA_W + CK_W,
    localparam int LINE_W  = WORDS * DATA_W,
    localparam int CHUNK_W = CHUNK_WORDS * DATA_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cpu_req,
    input  logic               cpu_we,
    input  logic               cpu_nocache,
    input  logic [ADDR_W-1:0]  cpu_addr,
    input  logic [DATA_W-1:0]  cpu_wdata,
    output logic               cpu_ack,
    output logic [DATA_W-1:0]  cpu_rdata,
    input  logic               snp_valid,
    input  logic               snp_write,
    input  logic [SA_W-1:0]    snp_caddr,
    input  logic [CHUNK_W-1:0] snp_wdata,
    output logic               snp_ack,
    output logic               snp_hit,
    output logic [CHUNK_W-1:0] snp_rdata,
    output logic               l2_req,
    output logic               l2_we,
    output logic [LA_W-1:0]    l2_addr,
    output logic               l2_alloc,
    output logic               l2_way,
    output logic [LINE_W-1:0]  l2_wdata,
    input  logic               l2_ack,
    input  logic [LINE_W-1:0]  l2_rdata
);
    import l1s_pkg::*;

    ctl_state_t        state_q;
    logic [LA_W-1:0]   la_q, wb_la_q;
    logic              alloc_q, way_q;
    logic [LINE_W-1:0] wb_line_q;
    logic [DATA_W-1:0] nc_word_q;

    logic [OFF_W-1:0]   c_off;
    logic [IDX_W-1:0]   c_idx, s_idx;
    logic [TAG_W-1:0]   c_tag, s_tag, vic_tag;
    logic [CK_W-1:0]    s_chunk;
    logic               a_hit, a_way, b_hit, b_way;
    logic               vic_way, vic_valid, vic_dirty, cpu_way;
    logic               serve, hit_acc, miss_start, alloc_now, fill_en;
    logic [LINE_W-1:0]  rd_line;
    logic [CHUNK_W-1:0] sn_rdata;

    // Address field split for the CPU and snoop sides.
    assign c_off   = cpu_addr[OFF_W-1:0];
    assign c_idx   = cpu_addr[OFF_W +: IDX_W];
    assign c_tag   = cpu_addr[ADDR_W-1 -: TAG_W];
    assign s_chunk = snp_caddr[CK_W-1:0];
    assign s_idx   = snp_caddr[CK_W +: IDX_W];
    assign s_tag   = snp_caddr[SA_W-1 -: TAG_W];

    // CPU service decisions; a snoop blocks the CPU for its cycle.
    assign serve      = (state_q == ST_IDLE) && cpu_req && !snp_valid;
    assign hit_acc    = serve && a_hit;
    assign miss_start = serve && !a_hit;
    assign alloc_now  = cpu_we || !cpu_nocache;
    assign cpu_way    = a_hit ? a_way : vic_way;
    assign fill_en    = (state_q == ST_FILL) && l2_ack && alloc_q;

    assign cpu_ack   = hit_acc || ((state_q == ST_NCRET) && !snp_valid);
    assign cpu_rdata = (state_q == ST_NCRET) ? nc_word_q : rd_line[c_off*DATA_W +: DATA_W];

    assign l2_req   = (state_q == ST_WBACK) || (state_q == ST_FILL);
    assign l2_we    = (state_q == ST_WBACK);
    assign l2_addr  = (state_q == ST_WBACK) ? wb_la_q : la_q;
    assign l2_alloc = alloc_q;
    assign l2_way   = way_q;
    assign l2_wdata = wb_line_q;

    l1s_tag_store #(.SETS(SETS), .TAG_W(TAG_W)) tags_i (
        .clk(clk), .rst_n(rst_n),
        .a_idx(c_idx), .a_tag(c_tag), .a_hit(a_hit), .a_way(a_way),
        .b_idx(s_idx), .b_tag(s_tag), .b_hit(b_hit), .b_way(b_way),
        .vic_way(vic_way), .vic_valid(vic_valid), .vic_dirty(vic_dirty), .vic_tag(vic_tag),
        .touch_en(hit_acc), .touch_way(a_way), .touch_dirty(cpu_we),
        .inval_en(miss_start && alloc_now && vic_valid), .inval_way(vic_way),
        .fill_en(fill_en), .fill_idx(la_q[IDX_W-1:0]), .fill_way(way_q),
        .fill_tag(la_q[LA_W-1:IDX_W])
    );

    l1s_data_store #(.SETS(SETS), .WORDS(WORDS), .CHUNK_WORDS(CHUNK_WORDS),
                     .DATA_W(DATA_W)) data_i (
        .clk(clk),
        .rd_idx(c_idx), .rd_way(cpu_way), .rd_line(rd_line),
        .wr_word_en(hit_acc && cpu_we), .wr_off(c_off), .wr_word(cpu_wdata),
        .sn_idx(s_idx), .sn_way(b_way), .sn_chunk(s_chunk), .sn_rdata(sn_rdata),
        .sn_wr_en(snp_valid && snp_write && b_hit), .sn_wdata(snp_wdata),
        .fill_en(fill_en), .fill_idx(la_q[IDX_W-1:0]), .fill_way(way_q),
        .fill_line(l2_rdata)
    );

    // Miss controller: write-back, line read and non-allocated return.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            alloc_q <= 1'b0;
            way_q   <= 1'b0;
        end else begin
            case (state_q)
                ST_IDLE: if (miss_start) begin
                    alloc_q <= alloc_now;
                    way_q   <= vic_way;
                    state_q <= (alloc_now && vic_valid && vic_dirty) ? ST_WBACK : ST_FILL;
                end
                ST_WBACK: if (l2_ack) state_q <= ST_FILL;
                ST_FILL:  if (l2_ack) state_q <= alloc_q ? ST_IDLE : ST_NCRET;
                default:  if (!snp_valid) state_q <= ST_IDLE;
            endcase
        end
    end

    // Miss context captured at miss start and at the non-allocated return.
    always_ff @(posedge clk) begin
        if (miss_start) begin
            la_q      <= cpu_addr[ADDR_W-1:OFF_W];
            wb_la_q   <= {vic_tag, c_idx};
            wb_line_q <= rd_line;
        end
        if (state_q == ST_FILL && l2_ack) nc_word_q <= l2_rdata[c_off*DATA_W +: DATA_W];
    end

    // Registered snoop response.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            snp_ack   <= 1'b0;
            snp_hit   <= 1'b0;
            snp_rdata <= '0;
        end else begin
            snp_ack   <= snp_valid;
            snp_hit   <= snp_valid && b_hit;
            snp_rdata <= (snp_valid && b_hit && !snp_write) ? sn_rdata : '0;
        end
    end
endmodule

// File: rtl/l1_snoop_cache_chk.sv
// Port-level protocol checks for l1_snoop_cache, attached by bind.
module l1_snoop_cache_chk #(
    parameter int LA_W    = 12,
    parameter int CHUNK_W = 256
) (
    input logic               clk,
    input logic               rst_n,
    input logic               cpu_ack,
    input logic               snp_valid,
    input logic               snp_ack,
    input logic               snp_hit,
    input logic [CHUNK_W-1:0] snp_rdata,
    input logic               l2_req,
    input logic               l2_we,
    input logic [LA_W-1:0]    l2_addr,
    input logic               l2_alloc,
    input logic               l2_ack
);
    // R8
    snp_beats_cpu_chk: assert property (@(posedge clk) disable iff (!rst_n)
        snp_valid |-> !cpu_ack);
    // R2
    snp_resp_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
        snp_valid |=> snp_ack);
    // R10
    snp_no_spurious_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !snp_valid |=> !snp_ack);
    // R10
    snp_miss_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (snp_ack && !snp_hit) |-> (snp_rdata == '0));
    // R7
    l2_req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (l2_req && !l2_ack) |=> (l2_req && $stable(l2_addr) && $stable(l2_we)));
    // R6
    wb_then_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (l2_req && l2_we && l2_ack) |=> (l2_req && !l2_we));
    // R6
    wb_alloc_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (l2_req && l2_we) |-> l2_alloc);
endmodule

bind l1_snoop_cache l1_snoop_cache_chk #(.LA_W(LA_W), .CHUNK_W(CHUNK_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .cpu_ack(cpu_ack), .snp_valid(snp_valid),
    .snp_ack(snp_ack), .snp_hit(snp_hit), .snp_rdata(snp_rdata),
    .l2_req(l2_req), .l2_we(l2_we), .l2_addr(l2_addr), .l2_alloc(l2_alloc),
    .l2_ack(l2_ack)
);

// File: tb/l1_snoop_cache_tb_top.sv
// Directed sweeps over a 2-set, 4-word-line, 2-word-chunk build.
module l1_snoop_cache_tb_top;
    localparam int AW = 8, DW = 16, NS = 2, NW = 4, CW = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_req = 0, cpu_we = 0, cpu_nocache = 0;
    logic [7:0]  cpu_addr = 0;
    logic [15:0] cpu_wdata = 0;
    logic        cpu_ack;
    logic [15:0] cpu_rdata;
    logic        snp_valid = 0, snp_write = 0;
    logic [6:0]  snp_caddr = 0;
    logic [31:0] snp_wdata = 0;
    logic        snp_ack, snp_hit;
    logic [31:0] snp_rdata;
    logic        l2_req, l2_we, l2_alloc, l2_way;
    logic [5:0]  l2_addr;
    logic [63:0] l2_wdata;
    logic        l2_ack = 0;
    logic [63:0] l2_rdata = 0;

    int n_chk = 0, n_fail = 0;
    int rd_cnt = 0, wb_cnt = 0;
    logic [5:0]  rd_addr_l = 0, wb_addr_l = 0;
    logic        rd_alloc_l = 0, rd_way_l = 0;
    logic [63:0] wb_data_l = 0;

    always #5 clk = ~clk;

    l1_snoop_cache #(.ADDR_W(AW), .DATA_W(DW), .SETS(NS), .WORDS(NW),
                     .CHUNK_WORDS(CW)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_nocache(cpu_nocache),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_ack(cpu_ack),
        .cpu_rdata(cpu_rdata),
        .snp_valid(snp_valid), .snp_write(snp_write), .snp_caddr(snp_caddr),
        .snp_wdata(snp_wdata), .snp_ack(snp_ack), .snp_hit(snp_hit),
        .snp_rdata(snp_rdata),
        .l2_req(l2_req), .l2_we(l2_we), .l2_addr(l2_addr), .l2_alloc(l2_alloc),
        .l2_way(l2_way), .l2_wdata(l2_wdata), .l2_ack(l2_ack), .l2_rdata(l2_rdata)
    );

    // Level-2 memory content as a function of the word address.
    function automatic logic [15:0] pat(input int a);
        return 16'(16'h5A00 ^ (a * 37));
    endfunction

    function automatic logic [63:0] mkline(input int la);
        logic [63:0] l;
        for (int k = 0; k < 4; k++) l[k*16 +: 16] = pat(la * 4 + k);
        return l;
    endfunction

    function automatic logic [7:0] ad(input int tag, input int set, input int off);
        return 8'(tag * 8 + set * 4 + off);
    endfunction

    function automatic logic [6:0] ca(input int tag, input int set, input int chunk);
        return 7'((tag * 2 + set) * 2 + chunk);
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    task automatic cpu_op(input logic we, input logic nc, input logic [7:0] a,
                          input logic [15:0] wd, output logic [15:0] rd);
        @(negedge clk);
        cpu_req = 1; cpu_we = we; cpu_nocache = nc; cpu_addr = a; cpu_wdata = wd;
        #1;
        while (!cpu_ack) begin
            @(negedge clk);
            #1;
        end
        rd = cpu_rdata;
        @(posedge clk);
        #1;
        cpu_req = 0; cpu_we = 0; cpu_nocache = 0;
    endtask

    task automatic snoop(input logic wr, input logic [6:0] a, input logic [31:0] wd,
                         output logic ack, output logic hit, output logic [31:0] rd);
        @(negedge clk);
        snp_valid = 1; snp_write = wr; snp_caddr = a; snp_wdata = wd;
        @(negedge clk);
        snp_valid = 0; snp_write = 0;
        ack = snp_ack; hit = snp_hit; rd = snp_rdata;
    endtask

    // Level-2 responder: acknowledges each request one negedge after seeing it.
    initial begin
        forever begin
            @(negedge clk);
            if (l2_ack) l2_ack = 0;
            else if (l2_req) begin
                l2_ack = 1;
                if (l2_we) begin
                    wb_cnt++; wb_addr_l = l2_addr; wb_data_l = l2_wdata;
                end else begin
                    rd_cnt++; rd_addr_l = l2_addr; rd_alloc_l = l2_alloc; rd_way_l = l2_way;
                    l2_rdata = mkline(int'(l2_addr));
                end
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        logic [15:0] rd;
        logic        ack, hit;
        logic [31:0] srd;
        int          rc, wc;
        repeat (3) @(negedge clk);
        rst_n = 1;

        // R1 / R10: empty cache after reset
        chk("R1 no l2 request", 64'(l2_req), 64'd0);
        snoop(1'b0, ca(0, 0, 0), 32'd0, ack, hit, srd);
        chk("R1 snoop ack", 64'(ack), 64'd1);
        chk("R1 snoop miss", 64'(hit), 64'd0);
        chk("R10 miss data zero", 64'(srd), 64'd0);

        // R7 / R9 / R11: every word of every set and way
        for (int s = 0; s < 2; s++)
            for (int t = 0; t < 2; t++)
                for (int o = 0; o < 4; o++) begin
                    rc = rd_cnt;
                    cpu_op(1'b0, 1'b0, ad(t, s, o), 16'd0, rd);
                    chk("R11 load data", 64'(rd), 64'(pat(int'(ad(t, s, o)))));
                    if (o == 0) begin
                        chk("R7 one line read", 64'(rd_cnt), 64'(rc + 1));
                        chk("R7 alloc flag", 64'(rd_alloc_l), 64'd1);
                        chk("R9 empty way first", 64'(rd_way_l), 64'(t));
                        chk("R7 line address", 64'(rd_addr_l), 64'(t * 2 + s));
                    end else begin
                        chk("R11 hit no l2", 64'(rd_cnt), 64'(rc));
                    end
                end

        // R11: store hit then load back
        rc = rd_cnt;
        cpu_op(1'b1, 1'b0, ad(0, 0, 1), 16'hBEEF, rd);
        cpu_op(1'b0, 1'b0, ad(0, 0, 1), 16'd0, rd);
        chk("R11 store readback", 64'(rd), 64'hBEEF);
        chk("R11 store no l2", 64'(rd_cnt), 64'(rc));

        // R2: snoop-read of both chunks
        snoop(1'b0, ca(0, 0, 0), 32'd0, ack, hit, srd);
        chk("R2 hit", 64'(hit), 64'd1);
        chk("R2 chunk0", 64'(srd), 64'({16'hBEEF, pat(int'(ad(0, 0, 0)))}));
        snoop(1'b0, ca(0, 0, 1), 32'd0, ack, hit, srd);
        chk("R2 chunk1", 64'(srd), 64'({pat(int'(ad(0, 0, 3))), pat(int'(ad(0, 0, 2)))}));

        // R4: merges into clean tag1 and dirty tag0 of set 0
        snoop(1'b1, ca(1, 0, 1), 32'h1234_5678, ack, hit, srd);
        chk("R4 write hit", 64'(hit), 64'd1);
        snoop(1'b0, ca(1, 0, 1), 32'd0, ack, hit, srd);
        chk("R4 merged chunk", 64'(srd), 64'h1234_5678);
        snoop(1'b0, ca(1, 0, 0), 32'd0, ack, hit, srd);
        chk("R4 other chunk kept", 64'(srd), 64'({pat(int'(ad(1, 0, 1))), pat(int'(ad(1, 0, 0)))}));
        snoop(1'b1, ca(0, 0, 1), 32'hCAFE_F00D, ack, hit, srd);
        snoop(1'b1, ca(0, 1, 0), 32'hAAAA_5555, ack, hit, srd);
        cpu_op(1'b0, 1'b0, ad(0, 1, 0), 16'd0, rd);
        chk("R4 low word", 64'(rd), 64'h5555);
        cpu_op(1'b0, 1'b0, ad(0, 1, 1), 16'd0, rd);
        chk("R4 high word", 64'(rd), 64'hAAAA);
        cpu_op(1'b0, 1'b0, ad(0, 1, 2), 16'd0, rd);
        chk("R4 untouched word", 64'(rd), 64'(pat(int'(ad(0, 1, 2)))));

        // R3 / R5 / R9: set 0 LRU points at way 1 (clean, snooped tag1)
        snoop(1'b0, ca(1, 0, 0), 32'd0, ack, hit, srd);
        wc = wb_cnt;
        cpu_op(1'b0, 1'b0, ad(2, 0, 0), 16'd0, rd);
        chk("R5 clean victim no writeback", 64'(wb_cnt), 64'(wc));
        chk("R3 LRU kept across snoops", 64'(rd_way_l), 64'd1);
        chk("R9 fill data", 64'(rd), 64'(pat(int'(ad(2, 0, 0)))));
        snoop(1'b0, ca(1, 0, 0), 32'd0, ack, hit, srd);
        chk("R10 evicted line misses", 64'(hit), 64'd0);
        chk("R10 miss data zero", 64'(srd), 64'd0);

        // R6 / R3: dirty tag0 survives snoops and is written back
        snoop(1'b0, ca(0, 0, 0), 32'd0, ack, hit, srd);
        wc = wb_cnt;
        cpu_op(1'b0, 1'b0, ad(3, 0, 0), 16'd0, rd);
        chk("R3 dirty kept, writeback count", 64'(wb_cnt), 64'(wc + 1));
        chk("R6 writeback address", 64'(wb_addr_l), 64'd0);
        chk("R6 writeback data", wb_data_l,
            {16'hCAFE, 16'hF00D, 16'hBEEF, pat(int'(ad(0, 0, 0)))});
        chk("R9 LRU victim way", 64'(rd_way_l), 64'd0);
        chk("R6 fill after writeback", 64'(rd), 64'(pat(int'(ad(3, 0, 0)))));

        // R7: non-allocating loads
        rc = rd_cnt; wc = wb_cnt;
        cpu_op(1'b0, 1'b1, ad(4, 1, 2), 16'd0, rd);
        chk("R7 nocache data", 64'(rd), 64'(pat(int'(ad(4, 1, 2)))));
        chk("R7 nocache alloc flag", 64'(rd_alloc_l), 64'd0);
        chk("R7 nocache no writeback", 64'(wb_cnt), 64'(wc));
        snoop(1'b0, ca(4, 1, 1), 32'd0, ack, hit, srd);
        chk("R7 nocache not allocated", 64'(hit), 64'd0);
        cpu_op(1'b0, 1'b1, ad(4, 1, 2), 16'd0, rd);
        chk("R7 nocache read again", 64'(rd_cnt), 64'(rc + 2));
        cpu_op(1'b0, 1'b1, ad(0, 1, 1), 16'd0, rd);
        chk("R7 nocache hit from cache", 64'(rd), 64'hAAAA);
        chk("R7 nocache hit no l2", 64'(rd_cnt), 64'(rc + 2));

        // R8: snoop and CPU load in the same cycle
        @(negedge clk);
        cpu_req = 1; cpu_we = 0; cpu_nocache = 0; cpu_addr = ad(0, 1, 3);
        snp_valid = 1; snp_write = 0; snp_caddr = ca(1, 1, 0);
        #1;
        chk("R8 cpu stalled", 64'(cpu_ack), 64'd0);
        @(negedge clk);
        snp_valid = 0;
        #1;
        chk("R8 cpu served next", 64'(cpu_ack), 64'd1);
        chk("R8 cpu data", 64'(cpu_rdata), 64'(pat(int'(ad(0, 1, 3)))));
        chk("R8 snoop answered", 64'({snp_ack, snp_hit}), 64'd3);
        chk("R2 snoop data", 64'(snp_rdata),
            64'({pat(int'(ad(1, 1, 1))), pat(int'(ad(1, 1, 0)))}));
        @(posedge clk);
        #1;
        cpu_req = 0;

        repeat (3) @(negedge clk);
        finish_run();
    end
endmodule